// File: doc/BRIEF.md
# Overtemperature Flag Latch

This block turns a stream of conversion results into a sticky overtemperature indication. Each finished conversion arrives as a one-cycle valid strobe together with a channel number and a result word. Only results from the temperature channel are considered. The most significant eight bits of such a result are compared with a programmable threshold. When they exceed it, an internal flag is set and the output pad is told to pull low.

The flag stays set, whatever later temperatures are, until the serial interface reports that a read transaction has completed. The pad is open-drain. The block only produces a pull-low enable and never drives the line high. A configuration input chooses whether the asserted indication is the pulled-low state (the default) or the released state.

The threshold register resets to a safe default and can be rewritten at any time through a write-enable and data port. The ADC, the serial bus engine and the pad cell are outside this block.

Top module: `ot_flag_top`

## Requirements
- R1: Results whose channel number is not 0 never change the flag, whatever their value.
- R2: A channel 0 result sets the flag when its upper 8 bits (result bits 9 down to 2) are strictly greater than the threshold. Equal values do not set it, and the two low result bits have no effect.
- R3: Once set, the flag stays set when later channel 0 results are at or below the threshold.
- R4: A one-cycle `rd_done` pulse clears the flag. The output shows the change on the cycle after the pulse.
- R5: When a setting result and `rd_done` arrive in the same cycle, the flag ends up set.
- R6: The threshold is 0x50 after reset. A write with `sp_we` high loads `sp_wdata`, and the new threshold applies to results from the next cycle on.
- R7: With `cfg_act_high` = 0, `ot_pull_low` is 1 exactly when the flag is set. With `cfg_act_high` = 1, `ot_pull_low` is 1 exactly when the flag is clear.
- R8: After reset the flag is clear, so `ot_pull_low` is 0 under the default polarity.
- R9: Result data presented with `res_vld` low is ignored. A `rd_done` pulse while the flag is already clear leaves it clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| res_vld | input | 1 | One-cycle strobe: a conversion result is present |
| res_chan | input | 2 | Channel number of the result |
| res_data | input | 10 | Conversion result word |
| sp_we | input | 1 | Threshold write enable |
| sp_wdata | input | 8 | Threshold write data |
| rd_done | input | 1 | One-cycle strobe: a serial read transaction has finished |
| cfg_act_high | input | 1 | 0: indication is the pulled-low state; 1: indication is the released state |
| ot_pull_low | output | 1 | Pull-low enable for the open-drain pad |

## Verification
The comparison is tried with three kinds of channel 0 results. A value equal to the threshold separates a strict from a non-strict compare. A value whose low two bits are set but whose upper byte equals the threshold shows which bits are compared. A value one step above the threshold must set the flag. The same hot value is also sent on other channels and with the valid strobe low, to show that the channel filter and the strobe gate work. The flag's persistence is checked by sending cold results after it has been set, against a simultaneous read-done, and after a threshold rewrite. Finally the output is observed under both polarities, so that an inverted or ignored polarity input is caught.

// File: rtl/ot_pkg.sv
// Package: shared types for the overtemperature flag latch.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package ot_pkg;

    // Next-state action chosen for the sticky flag each cycle.
    typedef enum logic [1:0] {
        FLG_HOLD  = 2'd0,
        FLG_SET   = 2'd1,
        FLG_CLEAR = 2'd2
    } flag_action_e;

    // Meaning of the asserted indication at the pad.
    typedef enum logic {
        POL_ACT_LOW  = 1'b0,
        POL_ACT_HIGH = 1'b1
    } pad_pol_e;

endpackage

// File: rtl/ot_setpoint_reg.sv
// Threshold register. Loads write data on a write enable.
// Assumes a synchronous active-low reset to RST_VAL.
module ot_setpoint_reg #(
    parameter int              SET_W   = 8,
    parameter logic [SET_W-1:0] RST_VAL = 8'h50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SET_W-1:0] wdata,
    output logic [SET_W-1:0] sp_q
);

    // Holds the threshold; a write takes effect from the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= RST_VAL;
        end else if (we) begin
            sp_q <= wdata;
        end
    end

endmodule

// File: rtl/ot_temp_cmp.sv
// Combinational hot detector. Flags a valid result on the temperature
// channel whose upper SET_W bits are strictly above the threshold.
// When the result is narrower than the threshold, it is zero-extended.
module ot_temp_cmp #(
    parameter int RES_W   = 10,
    parameter int SET_W   = 8,
    parameter int CH_W    = 2,
    parameter int TEMP_CH = 0
) (
    input  logic             vld,
    input  logic [CH_W-1:0]  chan,
    input  logic [RES_W-1:0] data,
    input  logic [SET_W-1:0] sp,
    output logic             hot
);

    localparam logic [CH_W-1:0] TEMP_ID = CH_W'(TEMP_CH);

    logic [SET_W-1:0] upper;
    logic             is_temp;

    // Picks the compared field according to the relative widths.
    generate
        if (RES_W >= SET_W) begin : g_trunc
            assign upper = data[RES_W-1 -: SET_W];
        end else begin : g_extend
            assign upper = {{(SET_W-RES_W){1'b0}}, data};
        end
    endgenerate

    // Qualifies the result by strobe and channel, then compares.
    always_comb begin
        is_temp = vld && (chan == TEMP_ID);
        hot     = is_temp && (upper > sp);
    end

endmodule

// File: rtl/ot_flag_ctl.sv
// Sticky flag. Set by a hot result and cleared by a read-done strobe.
// If both arrive in one cycle, the set wins.
module ot_flag_ctl
    import ot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hot,
    input  logic rd_done,
    output logic flag_q
);

    flag_action_e act;

    // Chooses the action; the set condition has priority over the clear.
    always_comb begin
        if (hot) begin
            act = FLG_SET;
        end else if (rd_done) begin
            act = FLG_CLEAR;
        end else begin
            act = FLG_HOLD;
        end
    end

    // Applies the action to the flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            case (act)
                FLG_SET:   flag_q <= 1'b1;
                FLG_CLEAR: flag_q <= 1'b0;
                default:   flag_q <= flag_q;
            endcase
        end
    end

endmodule

// File: rtl/ot_pad_drv.sv
// Open-drain pad control. Maps the flag to a pull-low enable according
// to the selected polarity. Never asks the pad to drive high.
module ot_pad_drv
    import ot_pkg::*;
(
    input  logic flag,
    input  logic act_high,
    output logic pull_low
);

    pad_pol_e pol;

    // Pulls low when the flag is set (active-low) or clear (active-high).
    always_comb begin
        pol = pad_pol_e'(act_high);
        if (pol == POL_ACT_LOW) begin
            pull_low = flag;
        end else begin
            pull_low = !flag;
        end
    end

endmodule

// File: rtl/ot_flag_top.sv
// Top of the overtemperature flag latch. Wires the threshold register,
// the hot detector, the sticky flag and the pad control together.
// Assumes one-cycle strobes on res_vld and rd_done, synchronous to clk.
module ot_flag_top #(
    parameter int RES_W   = 10,
    parameter int SET_W   = 8,
    parameter int CH_W    = 2,
    parameter int TEMP_CH = 0,
    parameter logic [SET_W-1:0] SP_RST = 8'h50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_vld,
    input  logic [CH_W-1:0]  res_chan,
    input  logic [RES_W-1:0] res_data,
    input  logic             sp_we,
    input  logic [SET_W-1:0] sp_wdata,
    input  logic             rd_done,
    input  logic             cfg_act_high,
    output logic             ot_pull_low
);

    logic [SET_W-1:0] sp_q;
    logic             hot;
    logic             flag_q;

    ot_setpoint_reg #(
        .SET_W   (SET_W),
        .RST_VAL (SP_RST)
    ) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sp_we),
        .wdata (sp_wdata),
        .sp_q  (sp_q)
    );

    ot_temp_cmp #(
        .RES_W   (RES_W),
        .SET_W   (SET_W),
        .CH_W    (CH_W),
        .TEMP_CH (TEMP_CH)
    ) u_cmp (
        .vld  (res_vld),
        .chan (res_chan),
        .data (res_data),
        .sp   (sp_q),
        .hot  (hot)
    );

    ot_flag_ctl u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .hot     (hot),
        .rd_done (rd_done),
        .flag_q  (flag_q)
    );

    ot_pad_drv u_pad (
        .flag     (flag_q),
        .act_high (cfg_act_high),
        .pull_low (ot_pull_low)
    );

endmodule

// File: rtl/ot_flag_chk.sv
// Checker for ot_flag_top. Attached by bind. It observes the ports and the
// internal threshold and flag, and relates them over time.
module ot_flag_chk #(
    parameter int RES_W   = 10,
    parameter int SET_W   = 8,
    parameter int CH_W    = 2,
    parameter int TEMP_CH = 0,
    parameter logic [SET_W-1:0] SP_RST = 8'h50
) (
    input logic             clk,
    input logic             rst_n,
    input logic             res_vld,
    input logic [CH_W-1:0]  res_chan,
    input logic [RES_W-1:0] res_data,
    input logic             sp_we,
    input logic [SET_W-1:0] sp_wdata,
    input logic             rd_done,
    input logic             cfg_act_high,
    input logic             ot_pull_low,
    input logic [SET_W-1:0] sp_q,
    input logic             flag_q
);

    logic [SET_W-1:0] c_up;
    logic             c_temp;

    // Independent extraction of the compared field.
    generate
        if (RES_W >= SET_W) begin : g_up
            assign c_up = SET_W'(res_data >> (RES_W - SET_W));
        end else begin : g_up_ext
            assign c_up = SET_W'(res_data);
        end
    endgenerate

    assign c_temp = res_vld && (res_chan == CH_W'(TEMP_CH));

    AST_OTHER_CH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_temp && !rd_done) |=> (flag_q == $past(flag_q))); // R1

    AST_HOT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (c_temp && (c_up > sp_q)) |=> flag_q); // R2

    AST_NO_SET_WHEN_COLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !(c_temp && (c_up > sp_q))) |=> !flag_q); // R2

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !(c_temp && (c_up > sp_q))) |=> !flag_q); // R4

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && c_temp && (c_up > sp_q)) |=> flag_q); // R5

    AST_SP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |=> (sp_q == $past(sp_wdata))); // R6

    AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_we |=> $stable(sp_q)); // R6

    AST_PAD_ACT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_act_high |-> (ot_pull_low == flag_q)); // R7

    AST_PAD_ACT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_act_high |-> (ot_pull_low != flag_q)); // R7

endmodule

bind ot_flag_top ot_flag_chk #(
    .RES_W   (RES_W),
    .SET_W   (SET_W),
    .CH_W    (CH_W),
    .TEMP_CH (TEMP_CH),
    .SP_RST  (SP_RST)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .res_vld      (res_vld),
    .res_chan     (res_chan),
    .res_data     (res_data),
    .sp_we        (sp_we),
    .sp_wdata     (sp_wdata),
    .rd_done      (rd_done),
    .cfg_act_high (cfg_act_high),
    .ot_pull_low  (ot_pull_low),
    .sp_q         (sp_q),
    .flag_q       (flag_q)
);

// File: tb/sim_ot_flag_top.sv
// Directed bench for ot_flag_top. Inputs are driven on the falling edge,
// and outputs are sampled on the following falling edge.
module sim_ot_flag_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       res_vld;
    logic [1:0] res_chan;
    logic [9:0] res_data;
    logic       sp_we;
    logic [7:0] sp_wdata;
    logic       rd_done;
    logic       cfg_act_high;
    logic       ot_pull_low;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit exp_flag = 1'b0;

    always #5 clk = ~clk;

    ot_flag_top u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .res_vld      (res_vld),
        .res_chan     (res_chan),
        .res_data     (res_data),
        .sp_we        (sp_we),
        .sp_wdata     (sp_wdata),
        .rd_done      (rd_done),
        .cfg_act_high (cfg_act_high),
        .ot_pull_low  (ot_pull_low)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Compares the output with the value the expected flag implies.
    task automatic chk(input string req);
        logic exp_pin;
        exp_pin = cfg_act_high ? !exp_flag : exp_flag;
        checks = checks + 1;
        if (ot_pull_low !== exp_pin) begin
            errors = errors + 1;
            $display("FAIL %s: ot_pull_low actual %b expected %b", req, ot_pull_low, exp_pin);
        end
    endtask

    // Presents one cycle of stimulus, then returns at the next falling edge.
    task automatic step(input logic vld, input logic [1:0] ch, input logic [9:0] d,
                        input logic rd);
        res_vld  = vld;
        res_chan = ch;
        res_data = d;
        rd_done  = rd;
        @(negedge clk);
        res_vld  = 1'b0;
        rd_done  = 1'b0;
    endtask

    task automatic write_sp(input logic [7:0] v);
        sp_we    = 1'b1;
        sp_wdata = v;
        @(negedge clk);
        sp_we    = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        res_vld = 1'b0; res_chan = '0; res_data = '0;
        sp_we = 1'b0; sp_wdata = '0; rd_done = 1'b0; cfg_act_high = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_flag = 1'b0;
        chk("R8 reset clear");
    endtask

    task automatic t_compare;
        step(1'b1, 2'd0, 10'h140, 1'b0);   // upper 0x50 == reset threshold
        chk("R2 equal no set / R6 reset threshold 0x50");
        step(1'b1, 2'd0, 10'h143, 1'b0);   // low bits set, upper still 0x50
        chk("R2 low bits ignored");
        step(1'b1, 2'd1, 10'h3FF, 1'b0);
        chk("R1 channel 1 ignored");
        step(1'b1, 2'd3, 10'h3FF, 1'b0);
        chk("R1 channel 3 ignored");
        step(1'b0, 2'd0, 10'h3FF, 1'b0);
        chk("R9 strobe low ignored");
        step(1'b1, 2'd0, 10'h144, 1'b0);   // upper 0x51 > 0x50
        exp_flag = 1'b1;
        chk("R2 greater sets");
    endtask

    task automatic t_sticky;
        step(1'b1, 2'd0, 10'h000, 1'b0);
        chk("R3 cold result keeps flag");
        step(1'b1, 2'd2, 10'h000, 1'b0);
        chk("R1 other channel keeps flag");
        step(1'b0, 2'd0, 10'h000, 1'b1);
        exp_flag = 1'b0;
        chk("R4 read done clears");
        step(1'b0, 2'd0, 10'h000, 1'b1);
        chk("R9 read done on clear flag");
    endtask

    task automatic t_collision;
        step(1'b1, 2'd0, 10'h3FC, 1'b1);
        exp_flag = 1'b1;
        chk("R5 set wins over read done");
        step(1'b0, 2'd0, 10'h000, 1'b1);
        exp_flag = 1'b0;
        chk("R4 clear after collision");
    endtask

    task automatic t_setpoint;
        write_sp(8'h20);
        step(1'b1, 2'd0, 10'h080, 1'b0);   // upper 0x20 == new threshold
        chk("R6 new threshold equal no set");
        step(1'b1, 2'd0, 10'h084, 1'b0);   // upper 0x21
        exp_flag = 1'b1;
        chk("R6 new threshold greater sets");
        step(1'b0, 2'd0, 10'h000, 1'b1);
        exp_flag = 1'b0;
        write_sp(8'hFF);
        step(1'b1, 2'd0, 10'h3FF, 1'b0);   // upper 0xFF, not above 0xFF
        chk("R2 max threshold never exceeded");
    endtask

    task automatic t_polarity;
        cfg_act_high = 1'b1;
        #1;
        chk("R7 active-high with flag clear");
        write_sp(8'h10);
        step(1'b1, 2'd0, 10'h200, 1'b0);
        exp_flag = 1'b1;
        chk("R7 active-high with flag set");
        cfg_act_high = 1'b0;
        #1;
        chk("R7 back to active-low with flag set");
        step(1'b0, 2'd0, 10'h000, 1'b1);
        exp_flag = 1'b0;
        chk("R7 active-low released after clear");
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_compare;
        t_sticky;
        t_collision;
        t_setpoint;
        t_polarity;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule